// File: doc/BRIEF.md
# Interrupt Status and Signalling Unit

This unit keeps a 32-bit word of pending interrupt causes. Several hardware sources and a software raise port can set bits in it, and a software acknowledge port can clear them. From that word it drives two kinds of interrupt signalling. In legacy mode it drives a level-sensitive interrupt line. In message mode it emits a one-clock pulse that stands for a message write.

In message mode every raise that leaves the word non-zero sends a fresh pulse, even if the raised bits were already pending. The level line is controlled only by raise and acknowledge operations made in legacy mode, and it stays unchanged while message mode is on. The cause encodings used by the surrounding device are bit 0 (value 0x00000001) for compute-done and bit 8 (value 0x00000100) for transfer-done. Software may raise any bit it likes.

The level line is a two-state machine:
- `LINE_LOW` moves to `LINE_HIGH` on transition *assert*: a legacy-mode raise whose resulting word is non-zero.
- `LINE_HIGH` moves to `LINE_LOW` on transition *drop*: a legacy-mode acknowledge whose resulting word is zero.
- Every other cycle takes transition *hold* and keeps the current state.

Top module: `isu_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the status word reads 0, the level line is 0 and the pulse is 0.
- R2: A raise ORs its mask into the status word. This covers any source strobe, the software raise port, or several of them in one cycle, and the new word is visible one clock after the strobe. The cause constants are bit 0 = 0x00000001 (compute-done) and bit 8 = 0x00000100 (transfer-done).
- R3: An acknowledge clears the bits set in its mask (word AND NOT mask) and leaves all other bits unchanged, one clock after the strobe.
- R4: When a raise and an acknowledge occur in the same cycle, the acknowledge is applied first and the raise second. A bit that is both acknowledged and raised therefore ends up set.
- R5: In legacy mode (message enable 0), a raise whose resulting word is non-zero sets the level line to 1 one clock later, and it produces no pulse.
- R6: In message mode (message enable 1), a raise whose resulting word is non-zero produces a pulse of exactly one clock, one clock later. Any number of simultaneous raises yield a single pulse. A raise of bits that are already pending still pulses. With no raise, the pulse is 0.
- R7: An acknowledge drops the level line only if the resulting word is zero and message mode is off. Otherwise the line keeps its value. While message mode is on, the level line never changes.
- R8: A raise whose resulting word is zero (an empty mask on an empty word) produces neither a pulse nor a change of the level line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_raise_vld | input | NUM_SRC | Per-source raise strobe |
| src_raise_mask | input | NUM_SRC*W | Per-source raise masks, source i at bits [i*W +: W] |
| sw_raise_vld | input | 1 | Software raise strobe |
| sw_raise_mask | input | W | Software raise mask |
| sw_ack_vld | input | 1 | Software acknowledge strobe |
| sw_ack_mask | input | W | Bits to clear |
| msg_mode | input | 1 | 1 = message signalling, 0 = level line |
| status | output | W | Pending-cause word |
| irq_level | output | 1 | Level-sensitive interrupt |
| msg_pulse | output | 1 | One-clock message pulse |

## Verification
The assertions check the following on every cycle:
- a software raise sets its bits;
- a lone acknowledge clears its bits;
- pulses appear only after a message-mode raise;
- a legacy raise that leaves bits pending raises the line;
- the line is frozen in message mode.

Some behaviours depend on sequence and history, and only the bench scenarios can show them:
- acknowledge-before-raise ordering within one cycle;
- the single pulse for simultaneous multi-source raises;
- the line staying high after an acknowledge to zero made in message mode;
- the line then dropping on a later legacy acknowledge.

// File: rtl/isu_pkg.sv
package isu_pkg;
    localparam int unsigned ISU_W = 32;
    localparam logic [ISU_W-1:0] CAUSE_COMPUTE = 32'h0000_0001;
    localparam logic [ISU_W-1:0] CAUSE_XFER    = 32'h0000_0100;

    typedef enum logic {
        LINE_LOW  = 1'b0,
        LINE_HIGH = 1'b1
    } line_state_e;
endpackage

// File: rtl/isu_raise_merge.sv
module isu_raise_merge #(
    parameter int unsigned NUM_SRC = 2,
    parameter int unsigned W       = 32
) (
    input  logic [NUM_SRC-1:0]   src_vld,
    input  logic [NUM_SRC*W-1:0] src_mask,
    input  logic                 sw_vld,
    input  logic [W-1:0]         sw_mask,
    output logic                 raise_any,
    output logic [W-1:0]         raise_mask
);
    localparam int unsigned NIN = NUM_SRC + 1;

    logic [W-1:0] gated [NIN];
    logic [NIN-1:0] vld_all;

    assign vld_all = {sw_vld, src_vld};

    for (genvar g = 0; g < NIN; g++) begin : g_gate
        if (g < NUM_SRC) begin : g_hw
            assign gated[g] = src_vld[g] ? src_mask[g*W +: W] : '0;
        end else begin : g_sw
            assign gated[g] = sw_vld ? sw_mask : '0;
        end
    end

    always_comb begin
        raise_mask = '0;
        for (int i = 0; i < NIN; i++) begin
            raise_mask = raise_mask | gated[i];
        end
    end

    assign raise_any = |vld_all;
endmodule

// File: rtl/isu_status_reg.sv
module isu_status_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         raise_any,
    input  logic [W-1:0] raise_mask,
    input  logic         ack_vld,
    input  logic [W-1:0] ack_mask,
    output logic [W-1:0] status_q,
    output logic         nxt_nonzero
);
    logic [W-1:0] after_ack;
    logic [W-1:0] status_nxt;

    // acknowledge first, then raise: a new event survives a same-cycle clear
    always_comb begin
        after_ack  = ack_vld ? (status_q & ~ack_mask) : status_q;
        status_nxt = raise_any ? (after_ack | raise_mask) : after_ack;
    end

    assign nxt_nonzero = |status_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_nxt;
    end
endmodule

// File: rtl/isu_line_fsm.sv
module isu_line_fsm
    import isu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise_any,
    input  logic ack_vld,
    input  logic nxt_nonzero,
    input  logic msg_mode,
    output logic irq_level,
    output logic msg_pulse
);
    line_state_e state_q, state_d;
    logic        pulse_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_LOW: begin
                if (!msg_mode && raise_any && nxt_nonzero) state_d = LINE_HIGH;
            end
            LINE_HIGH: begin
                if (!msg_mode && ack_vld && !nxt_nonzero) state_d = LINE_LOW;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LINE_LOW;
        else        state_q <= state_d;
    end

    assign pulse_d = msg_mode && raise_any && nxt_nonzero;

    always_ff @(posedge clk) begin
        if (!rst_n) msg_pulse <= 1'b0;
        else        msg_pulse <= pulse_d;
    end

    assign irq_level = (state_q == LINE_HIGH);
endmodule

// File: rtl/isu_top.sv
module isu_top #(
    parameter int unsigned NUM_SRC = 2,
    parameter int unsigned W       = isu_pkg::ISU_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_raise_vld,
    input  logic [NUM_SRC*W-1:0] src_raise_mask,
    input  logic                 sw_raise_vld,
    input  logic [W-1:0]         sw_raise_mask,
    input  logic                 sw_ack_vld,
    input  logic [W-1:0]         sw_ack_mask,
    input  logic                 msg_mode,
    output logic [W-1:0]         status,
    output logic                 irq_level,
    output logic                 msg_pulse
);
    logic         raise_any;
    logic [W-1:0] raise_mask;
    logic         nxt_nonzero;

    isu_raise_merge #(.NUM_SRC(NUM_SRC), .W(W)) i_merge (
        .src_vld   (src_raise_vld),
        .src_mask  (src_raise_mask),
        .sw_vld    (sw_raise_vld),
        .sw_mask   (sw_raise_mask),
        .raise_any (raise_any),
        .raise_mask(raise_mask)
    );

    isu_status_reg #(.W(W)) i_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .raise_any  (raise_any),
        .raise_mask (raise_mask),
        .ack_vld    (sw_ack_vld),
        .ack_mask   (sw_ack_mask),
        .status_q   (status),
        .nxt_nonzero(nxt_nonzero)
    );

    isu_line_fsm i_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .raise_any  (raise_any),
        .ack_vld    (sw_ack_vld),
        .nxt_nonzero(nxt_nonzero),
        .msg_mode   (msg_mode),
        .irq_level  (irq_level),
        .msg_pulse  (msg_pulse)
    );
endmodule

// File: rtl/isu_chk.sv
module isu_chk #(
    parameter int unsigned NUM_SRC = 2,
    parameter int unsigned W       = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_SRC-1:0]   src_raise_vld,
    input logic                 sw_raise_vld,
    input logic [W-1:0]         sw_raise_mask,
    input logic                 sw_ack_vld,
    input logic [W-1:0]         sw_ack_mask,
    input logic                 msg_mode,
    input logic [W-1:0]         status,
    input logic                 irq_level,
    input logic                 msg_pulse
);
    logic any_raise;
    assign any_raise = (|src_raise_vld) || sw_raise_vld;

    assert_sw_raise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_raise_vld |=> ((status & $past(sw_raise_mask)) == $past(sw_raise_mask)));

    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_ack_vld && !any_raise) |=> ((status & $past(sw_ack_mask)) == '0));

    assert_legacy_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (any_raise && !msg_mode) |=> ((status == '0) || irq_level));

    assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_mode || !any_raise) |=> !msg_pulse);

    assert_msg_line_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        msg_mode |=> $stable(irq_level));
endmodule

bind isu_top isu_chk #(.NUM_SRC(NUM_SRC), .W(W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_raise_vld(src_raise_vld),
    .sw_raise_vld (sw_raise_vld),
    .sw_raise_mask(sw_raise_mask),
    .sw_ack_vld   (sw_ack_vld),
    .sw_ack_mask  (sw_ack_mask),
    .msg_mode     (msg_mode),
    .status       (status),
    .irq_level    (irq_level),
    .msg_pulse    (msg_pulse)
);

// File: tb/test_isu_top.sv
`timescale 1ns/1ps
module test_isu_top;
    localparam int NS = 3;
    localparam int W  = 32;
    localparam logic [W-1:0] C_COMP = 32'h0000_0001;
    localparam logic [W-1:0] C_XFER = 32'h0000_0100;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NS-1:0]     src_raise_vld;
    logic [NS*W-1:0]   src_raise_mask;
    logic              sw_raise_vld;
    logic [W-1:0]      sw_raise_mask;
    logic              sw_ack_vld;
    logic [W-1:0]      sw_ack_mask;
    logic              msg_mode;
    logic [W-1:0]      status;
    logic              irq_level;
    logic              msg_pulse;

    always #2.5 clk = ~clk;

    isu_top #(.NUM_SRC(NS), .W(W)) i_isu_top (
        .clk(clk), .rst_n(rst_n),
        .src_raise_vld(src_raise_vld), .src_raise_mask(src_raise_mask),
        .sw_raise_vld(sw_raise_vld), .sw_raise_mask(sw_raise_mask),
        .sw_ack_vld(sw_ack_vld), .sw_ack_mask(sw_ack_mask),
        .msg_mode(msg_mode),
        .status(status), .irq_level(irq_level), .msg_pulse(msg_pulse)
    );

    int total = 0;
    int bad   = 0;
    logic [W-1:0] m_status;
    logic         m_level;
    logic         m_pulse;

    task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic any_raise_f();
        return (|src_raise_vld) || sw_raise_vld;
    endfunction

    function automatic logic [W-1:0] raise_mask_f();
        logic [W-1:0] m = sw_raise_vld ? sw_raise_mask : '0;
        for (int i = 0; i < NS; i++)
            if (src_raise_vld[i]) m |= src_raise_mask[i*W +: W];
        return m;
    endfunction

    function automatic logic [W-1:0] next_status_f(logic [W-1:0] s);
        logic [W-1:0] t = sw_ack_vld ? (s & ~sw_ack_mask) : s;
        return any_raise_f() ? (t | raise_mask_f()) : t;
    endfunction

    task automatic idle();
        src_raise_vld = '0; src_raise_mask = '0;
        sw_raise_vld = 1'b0; sw_raise_mask = '0;
        sw_ack_vld = 1'b0; sw_ack_mask = '0;
    endtask

    // inputs are already driven at a negedge; advance one clock and compare
    task automatic step(string ts, string tl, string tp);
        logic [W-1:0] ns;
        ns = next_status_f(m_status);
        m_pulse = msg_mode && any_raise_f() && (ns != '0);
        if (!msg_mode && any_raise_f() && ns != '0) m_level = 1'b1;
        else if (!msg_mode && sw_ack_vld && ns == '0) m_level = 1'b0;
        m_status = ns;
        @(posedge clk);
        @(negedge clk);
        chk(ts, "status", status, m_status);
        chk(tl, "irq_level", {31'b0, irq_level}, {31'b0, m_level});
        chk(tp, "msg_pulse", {31'b0, msg_pulse}, {31'b0, m_pulse});
        idle();
    endtask

    function automatic logic [W-1:0] rnd_mask();
        case ($urandom_range(0, 4))
            0: return '0;
            1: return C_COMP;
            2: return C_XFER;
            default: return $urandom();
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; msg_mode = 1'b0; idle();
        m_status = '0; m_level = 1'b0; m_pulse = 1'b0;
        repeat (3) @(negedge clk);
        // R1: values during reset
        chk("R1", "status", status, '0);
        chk("R1", "irq_level", {31'b0, irq_level}, '0);
        chk("R1", "msg_pulse", {31'b0, msg_pulse}, '0);
        rst_n = 1'b1;
        step("R1", "R1", "R1");

        // R2, R5: two hardware causes at once in legacy mode
        src_raise_vld = 3'b011;
        src_raise_mask[0 +: W] = C_COMP;
        src_raise_mask[W +: W] = C_XFER;
        step("R2", "R5", "R5");
        // R3, R7: partial acknowledge keeps the line, full one drops it
        sw_ack_vld = 1'b1; sw_ack_mask = C_COMP;
        step("R3", "R7", "R7");
        sw_ack_vld = 1'b1; sw_ack_mask = C_XFER;
        step("R3", "R7", "R7");
        // R4: same-cycle acknowledge and raise of the same bit
        sw_raise_vld = 1'b1; sw_raise_mask = C_COMP;
        step("R2", "R5", "R5");
        sw_ack_vld = 1'b1; sw_ack_mask = 32'hFFFF_FFFF;
        sw_raise_vld = 1'b1; sw_raise_mask = C_COMP;
        step("R4", "R4", "R4");
        sw_ack_vld = 1'b1; sw_ack_mask = 32'hFFFF_FFFF;
        step("R3", "R7", "R7");
        // R8: empty raise on empty word, both modes
        sw_raise_vld = 1'b1; sw_raise_mask = '0;
        step("R8", "R8", "R8");
        msg_mode = 1'b1;
        src_raise_vld = 3'b001;
        step("R8", "R8", "R8");
        // R6: three sources at once -> single pulse, then nothing
        src_raise_vld = 3'b111;
        src_raise_mask = {32'h4, C_XFER, C_COMP};
        step("R2", "R7", "R6");
        step("R2", "R7", "R6");
        // R6: already pending bits still pulse
        src_raise_vld = 3'b001; src_raise_mask[0 +: W] = C_COMP;
        step("R2", "R7", "R6");
        // R7: line raised in legacy mode stays high after a message-mode clear
        sw_ack_vld = 1'b1; sw_ack_mask = 32'hFFFF_FFFF;
        step("R3", "R7", "R6");
        msg_mode = 1'b0;
        sw_raise_vld = 1'b1; sw_raise_mask = C_XFER;
        step("R2", "R5", "R5");
        msg_mode = 1'b1;
        sw_ack_vld = 1'b1; sw_ack_mask = C_XFER;
        step("R3", "R7", "R7");
        chk("R7", "line held after message-mode clear", {31'b0, irq_level}, 32'd1);
        msg_mode = 1'b0;
        sw_ack_vld = 1'b1; sw_ack_mask = '0;
        step("R3", "R7", "R7");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 49) == 0) msg_mode = ~msg_mode;
            for (int s = 0; s < NS; s++) begin
                src_raise_vld[s] = ($urandom_range(0, 3) == 0);
                src_raise_mask[s*W +: W] = rnd_mask();
            end
            sw_raise_vld = ($urandom_range(0, 4) == 0);
            sw_raise_mask = rnd_mask();
            sw_ack_vld = ($urandom_range(0, 2) == 0);
            sw_ack_mask = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : rnd_mask();
            step("R2/R3/R4", "R5/R7", "R6/R8");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule